// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block is the always-on part of a chip that puts the rest of the chip to sleep and brings it back. Software writes a configuration word that picks one of three sleep depths, enables any of four wakeup lines and sets a divider for an external serial transfer engine. It then writes a sleep command. From there the block drives three control outputs: a PLL freeze, a power-cut request to the supply and a hold on the chip reset. The shallowest depth only stops the clock. The middle depth cuts power and resets the chip on wake. The deepest depth saves chip state to non-volatile storage before the cut and restores it after the wake. The state transfer itself is done by an external engine, which the block drives through a request/done handshake with a direction flag.

The block itself is reset only by the power-on reset. Its sticky status word therefore survives a wakeup reset of the chip. Firmware reads it after any reset to tell a wake from a cold start and to see which line caused the wake. The enabled wakeup lines are also combined onto one interrupt output, so that they can serve as ordinary interrupts while the chip runs.

Top module: `sleep_ctl`

## Requirements
- R1: `wake_irq` is high when any wakeup line whose enable bit is set is high. The lines pass through a two-flop synchronizer, so a line raised before edge k shows on `wake_irq` after edge k+1. A line whose enable bit is clear never raises `wake_irq`.
- R2: The mode field (configuration register, address 0, bits 1:0) encodes 00 none, 01 clock-suspend, 10 power-down and 11 standby. A sleep command (a write of bit 0 = 1 to address 2) given while the mode is 00 is ignored, and all control outputs stay low.
- R3: Clock-suspend raises only `pll_freeze`, one edge after the command. An enabled wake drops it again with no reset hold and no power cut, and the woke flag stays 0.
- R4: Power-down raises `pwr_off_req` and holds it until an enabled wake is seen. `chip_rst_hold` then stays high for exactly RST_HOLD_CYC (8) cycles, after which all control outputs are low. `pll_freeze` is not used in this mode.
- R5: Standby entry goes in order. The first cycle has `pll_freeze` alone. Then `xfer_req` rises with `xfer_dir` = 0 (save) while freeze stays high. `pwr_off_req` rises only on the edge after `xfer_done`, and `xfer_req` is never high together with `pwr_off_req`.
- R6: Standby wake goes in order. `chip_rst_hold` and `pll_freeze` are high for at least RST_HOLD_CYC cycles before `xfer_req` rises with `xfer_dir` = 1 (restore). Both stay high until `xfer_done`, and then all outputs drop together.
- R7: An enabled wake seen during the save phase is remembered. `pwr_off_req` is still raised for one cycle, and the wake sequence then follows even if the line has already dropped.
- R8: While asleep, only an enabled wakeup line ends the sleep. A disabled line that is high leaves the block asleep.
- R9: The status register (address 1) holds one sticky bit per wakeup line (bits 3:0, set while the enabled line is seen high) and a woke flag (bit 8, set on every power-down or standby wake). Writing 1 clears a bit, and a write of 0 leaves it unchanged.
- R10: `xfer_div` always equals the divider field of the configuration register (bits 15:8).
- R11: The configuration register reads back its mode (1:0), enable mask (7:4) and divider (15:8), with the other bits 0. It resets to all zeros, and so does the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 config, 1 status, 2 command |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| wake_in | input | 4 | Asynchronous wakeup lines |
| wake_irq | output | 1 | Combined interrupt from enabled wakeup lines |
| pll_freeze | output | 1 | Stops the PLL output |
| pwr_off_req | output | 1 | Asks the supply to cut chip power |
| chip_rst_hold | output | 1 | Holds the chip in reset |
| xfer_req | output | 1 | Requests a state transfer from the serial engine |
| xfer_dir | output | 1 | 0 save, 1 restore |
| xfer_div | output | 8 | Serial transfer clock divider |
| xfer_done | input | 1 | One-cycle pulse when the transfer has finished |

## Verification
A sequencer stuck in the wrong state shows at once on the control outputs, because they are decoded straight from the state. A skipped freeze cycle, a power cut raised while the save is still running, or a restore started under a short reset hold each changes the outputs within the cycle of the faulty transition. A lost pending wake shows only later, as `pwr_off_req` that never falls. A status bit that is set or cleared wrongly stays hidden until software reads address 1, so the checks read it after each wake and after each write-one-to-clear.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  localparam int WAKE_LINES = 4;

  typedef enum logic [1:0] {
    MODE_NONE    = 2'b00,
    MODE_CLKSUSP = 2'b01,
    MODE_PWRDN   = 2'b10,
    MODE_STBY    = 2'b11
  } sleep_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_CLK_SLP,
    ST_PD_OFF,
    ST_SB_FRZ,
    ST_SB_SAVE,
    ST_SB_OFF,
    ST_HOLD,
    ST_SB_REST
  } seq_state_e;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  localparam int MODE_LSB = 0;
  localparam int EN_LSB   = 4;
  localparam int DIV_LSB  = 8;
  localparam int WOKE_BIT = 8;

  // any enabled line high
  function automatic logic any_enabled(input logic [WAKE_LINES-1:0] lvl,
                                       input logic [WAKE_LINES-1:0] en);
    return |(lvl & en);
  endfunction

  // write-one-to-clear with set taking priority
  function automatic logic [WAKE_LINES-1:0] w1c_next(input logic [WAKE_LINES-1:0] cur,
                                                     input logic [WAKE_LINES-1:0] set,
                                                     input logic [WAKE_LINES-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/sleep_wake_sync.sv
module sleep_wake_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sleep_regs.sv
module sleep_regs
  import sleep_ctl_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 2,
  parameter int DIV_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic [WAKE_LINES-1:0] src_set,
  input  logic                  woke_set,
  output sleep_mode_e           mode,
  output logic [WAKE_LINES-1:0] wake_en,
  output logic [DIV_W-1:0]      div,
  output logic                  cmd_sleep
);

  logic [1:0]            mode_q;
  logic [WAKE_LINES-1:0] en_q;
  logic [DIV_W-1:0]      div_q;
  logic [WAKE_LINES-1:0] src_q;
  logic                  woke_q;

  logic wr_cfg, wr_stat;
  logic [WAKE_LINES-1:0] src_clr;
  logic                  woke_clr;

  assign wr_cfg   = reg_we && (reg_addr == AW'(ADDR_CFG));
  assign wr_stat  = reg_we && (reg_addr == AW'(ADDR_STAT));
  assign cmd_sleep = reg_we && (reg_addr == AW'(ADDR_CMD)) && reg_wdata[0];
  assign src_clr  = wr_stat ? reg_wdata[WAKE_LINES-1:0] : '0;
  assign woke_clr = wr_stat && reg_wdata[WOKE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      en_q   <= '0;
      div_q  <= '0;
    end else if (wr_cfg) begin
      mode_q <= reg_wdata[MODE_LSB +: 2];
      en_q   <= reg_wdata[EN_LSB +: WAKE_LINES];
      div_q  <= reg_wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      woke_q <= 1'b0;
    end else begin
      src_q  <= w1c_next(src_q, src_set, src_clr);
      woke_q <= woke_set | (woke_q & ~woke_clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(ADDR_CFG): begin
        reg_rdata[MODE_LSB +: 2]        = mode_q;
        reg_rdata[EN_LSB +: WAKE_LINES] = en_q;
        reg_rdata[DIV_LSB +: DIV_W]     = div_q;
      end
      AW'(ADDR_STAT): begin
        reg_rdata[WAKE_LINES-1:0] = src_q;
        reg_rdata[WOKE_BIT]       = woke_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign mode    = sleep_mode_e'(mode_q);
  assign wake_en = en_q;
  assign div     = div_q;

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_ctl_pkg::*;
#(
  parameter int RST_HOLD_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_sleep,
  input  sleep_mode_e mode,
  input  logic        wake_evt,
  input  logic        xfer_done,
  output logic        pll_freeze,
  output logic        pwr_off_req,
  output logic        chip_rst_hold,
  output logic        xfer_req,
  output logic        xfer_dir,
  output logic        woke_set,
  output logic        wake_pend
);

  localparam int CNT_W = $clog2(RST_HOLD_CYC + 1);

  seq_state_e  state_q, state_d;
  sleep_mode_e mode_q;
  logic        pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q;
  logic        hold_last;
  logic        enter_hold;

  function automatic logic hold_over(input logic [CNT_W-1:0] c);
    return c == CNT_W'(RST_HOLD_CYC - 1);
  endfunction

  assign hold_last = (state_q == ST_HOLD) && hold_over(cnt_q);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    case (state_q)
      ST_RUN: begin
        pend_d = 1'b0;
        if (cmd_sleep) begin
          case (mode)
            MODE_CLKSUSP: state_d = ST_CLK_SLP;
            MODE_PWRDN:   state_d = ST_PD_OFF;
            MODE_STBY:    state_d = ST_SB_FRZ;
            default:      state_d = ST_RUN;
          endcase
        end
      end
      ST_CLK_SLP: if (wake_evt) state_d = ST_RUN;
      ST_PD_OFF:  if (wake_evt) state_d = ST_HOLD;
      ST_SB_FRZ:  state_d = ST_SB_SAVE;
      ST_SB_SAVE: begin
        if (wake_evt) pend_d = 1'b1;
        if (xfer_done) state_d = ST_SB_OFF;
      end
      ST_SB_OFF: begin
        if (wake_evt || pend_q) begin
          state_d = ST_HOLD;
          pend_d  = 1'b0;
        end
      end
      ST_HOLD: if (hold_last) state_d = (mode_q == MODE_STBY) ? ST_SB_REST : ST_RUN;
      ST_SB_REST: if (xfer_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  assign enter_hold = (state_d == ST_HOLD) && (state_q != ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= MODE_NONE;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (state_q == ST_RUN && cmd_sleep) mode_q <= mode;
      if (state_q != ST_HOLD) cnt_q <= '0;
      else if (!hold_last)    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pll_freeze = (state_q == ST_CLK_SLP) || (state_q == ST_SB_FRZ) ||
                      (state_q == ST_SB_SAVE) || (state_q == ST_SB_OFF) ||
                      (state_q == ST_SB_REST) ||
                      ((state_q == ST_HOLD) && (mode_q == MODE_STBY));
  assign pwr_off_req   = (state_q == ST_PD_OFF) || (state_q == ST_SB_OFF);
  assign chip_rst_hold = (state_q == ST_HOLD) || (state_q == ST_SB_REST);
  assign xfer_req      = (state_q == ST_SB_SAVE) || (state_q == ST_SB_REST);
  assign xfer_dir      = (state_q == ST_SB_REST);
  assign woke_set      = enter_hold;
  assign wake_pend     = pend_q;

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int DW           = 16,
  parameter int AW           = 2,
  parameter int DIV_W        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_HOLD_CYC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic [WAKE_LINES-1:0] wake_in,
  output logic                  wake_irq,
  output logic                  pll_freeze,
  output logic                  pwr_off_req,
  output logic                  chip_rst_hold,
  output logic                  xfer_req,
  output logic                  xfer_dir,
  output logic [DIV_W-1:0]      xfer_div,
  input  logic                  xfer_done
);

  logic [WAKE_LINES-1:0] wake_sync;
  logic [WAKE_LINES-1:0] wake_en;
  logic [WAKE_LINES-1:0] src_set;
  sleep_mode_e           mode;
  logic                  cmd_sleep;
  logic                  wake_evt;
  logic                  woke_set;
  logic                  wake_pend;

  sleep_wake_sync #(.WIDTH(WAKE_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wake_in),
    .sync_out (wake_sync)
  );

  assign src_set  = wake_sync & wake_en;
  assign wake_evt = any_enabled(wake_sync, wake_en);
  assign wake_irq = wake_evt;

  sleep_regs #(.DW(DW), .AW(AW), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_set   (src_set),
    .woke_set  (woke_set),
    .mode      (mode),
    .wake_en   (wake_en),
    .div       (xfer_div),
    .cmd_sleep (cmd_sleep)
  );

  sleep_seq #(.RST_HOLD_CYC(RST_HOLD_CYC)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_sleep     (cmd_sleep),
    .mode          (mode),
    .wake_evt      (wake_evt),
    .xfer_done     (xfer_done),
    .pll_freeze    (pll_freeze),
    .pwr_off_req   (pwr_off_req),
    .chip_rst_hold (chip_rst_hold),
    .xfer_req      (xfer_req),
    .xfer_dir      (xfer_dir),
    .woke_set      (woke_set),
    .wake_pend     (wake_pend)
  );

endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk #(
  parameter int RST_HOLD_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic pll_freeze,
  input logic pwr_off_req,
  input logic chip_rst_hold,
  input logic xfer_req,
  input logic xfer_dir,
  input logic wake_evt,
  input logic wake_pend
);

  logic [7:0] rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rst_run <= '0;
    else if (!chip_rst_hold) rst_run <= '0;
    else if (rst_run != 8'hFF) rst_run <= rst_run + 8'd1;
  end

  // R5
  xfer_only_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> pll_freeze);

  // R5
  cut_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> !xfer_req);

  // R6
  restore_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_dir) |-> chip_rst_hold);

  // R4
  hold_after_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst_hold) |-> $past(pwr_off_req));

  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst_hold) |-> (int'(rst_run) >= RST_HOLD_CYC));

  // R6
  restore_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xfer_req) && xfer_dir) |-> (int'(rst_run) >= RST_HOLD_CYC));

  // R8
  stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off_req && !wake_evt && !wake_pend) |=> pwr_off_req);

endmodule

bind sleep_ctl sleep_ctl_chk #(.RST_HOLD_CYC(RST_HOLD_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pll_freeze    (pll_freeze),
  .pwr_off_req   (pwr_off_req),
  .chip_rst_hold (chip_rst_hold),
  .xfer_req      (xfer_req),
  .xfer_dir      (xfer_dir),
  .wake_evt      (wake_evt),
  .wake_pend     (wake_pend)
);

// File: tb/sleep_ctl_bench.sv
module sleep_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD_N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  wake_in = '0;
  logic        wake_irq, pll_freeze, pwr_off_req, chip_rst_hold, xfer_req, xfer_dir;
  logic [7:0]  xfer_div;
  logic        xfer_done = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_ctl u_sleep_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_in(wake_in),
    .wake_irq(wake_irq), .pll_freeze(pll_freeze), .pwr_off_req(pwr_off_req),
    .chip_rst_hold(chip_rst_hold), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
    .xfer_div(xfer_div), .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg(input logic [1:0] m, input logic [3:0] en, input logic [7:0] d);
    return {d, en, 2'b00, m};
  endfunction

  function automatic logic [3:0] outs();
    return {pll_freeze, pwr_off_req, chip_rst_hold, xfer_req};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R11 cfg reset", v, 16'h0);
    rd(2'd1, v); chk("R11 stat reset", v, 16'h0);
    chk("R11 outputs reset", {28'h0, outs()}, 32'h0);
  endtask

  task automatic t_cfg();
    logic [15:0] v;
    wr(2'd0, 16'hA5FD);
    rd(2'd0, v); chk("R11 cfg readback", v, 16'hA5F1);
    chk("R10 divider out", xfer_div, 8'hA5);
    wr(2'd0, cfg(2'b00, 4'b0101, 8'h3C));
    chk("R10 divider out 2", xfer_div, 8'h3C);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    @(negedge clk); wake_in = 4'b0010;
    repeat (3) @(negedge clk);
    chk("R1 disabled line no irq", wake_irq, 1'b0);
    wake_in = 4'b0100;
    @(negedge clk); chk("R1 irq after one edge", wake_irq, 1'b0);
    @(negedge clk); chk("R1 irq after two edges", wake_irq, 1'b1);
    wake_in = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1 irq drops", wake_irq, 1'b0);
    rd(2'd1, v); chk("R9 sticky source", v, 16'h0004);
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R9 write 0 keeps", v, 16'h0004);
    wr(2'd1, 16'h0004);
    rd(2'd1, v); chk("R9 w1c clears", v, 16'h0000);
  endtask

  task automatic t_none();
    wr(2'd2, 16'h0001);
    repeat (4) begin
      chk("R2 none mode ignored", {28'h0, outs()}, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic t_clk_susp();
    logic [15:0] v;
    wr(2'd0, cfg(2'b01, 4'b0101, 8'h3C));
    wr(2'd2, 16'h0001);
    chk("R3 freeze only", {28'h0, outs()}, 32'h8);
    wake_in = 4'b0010;
    repeat (6) @(negedge clk);
    chk("R8 disabled line keeps sleep", {28'h0, outs()}, 32'h8);
    wake_in = 4'b0001;
    @(negedge clk); @(negedge clk);
    chk("R3 still frozen before sync", pll_freeze, 1'b1);
    @(negedge clk);
    chk("R3 resumes without reset", {28'h0, outs()}, 32'h0);
    wake_in = 4'b0000;
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R3 woke flag stays 0", v, 16'h0001);
    wr(2'd1, 16'h010F);
  endtask

  task automatic t_power_down();
    logic [15:0] v;
    int n;
    wr(2'd0, cfg(2'b10, 4'b0101, 8'h3C));
    wr(2'd2, 16'h0001);
    chk("R4 power cut", {28'h0, outs()}, 32'h4);
    wake_in = 4'b1000;
    repeat (8) @(negedge clk);
    chk("R8 disabled keeps cut", pwr_off_req, 1'b1);
    wake_in = 4'b0100;
    @(negedge clk); @(negedge clk);
    chk("R4 cut held until wake", pwr_off_req, 1'b1);
    @(negedge clk);
    chk("R4 reset hold starts", {28'h0, outs()}, 32'h2);
    wake_in = 4'b0000;
    n = 0;
    while (chip_rst_hold && n < 100) begin n++; @(negedge clk); end
    chk("R4 hold length", n, HOLD_N);
    chk("R4 all released", {28'h0, outs()}, 32'h0);
    rd(2'd1, v); chk("R9 woke flag and source", v, 16'h0104);
    wr(2'd1, 16'h0100);
    rd(2'd1, v); chk("R9 woke flag clear", v, 16'h0004);
    wr(2'd1, 16'h0004);
  endtask

  task automatic t_standby(input bit early);
    logic [15:0] v;
    int n;
    wr(2'd0, cfg(2'b11, 4'b0101, 8'h3C));
    wr(2'd2, 16'h0001);
    chk("R5 freeze first", {28'h0, outs()}, 32'h8);
    @(negedge clk);
    chk("R5 save requested", {27'h0, outs(), xfer_dir}, 32'h12);
    if (early) begin
      wake_in = 4'b0001;
      repeat (3) @(negedge clk);
      wake_in = 4'b0000;
      repeat (3) @(negedge clk);
    end else begin
      repeat (5) @(negedge clk);
    end
    chk("R5 no cut before done", pwr_off_req, 1'b0);
    pulse_done();
    chk("R5 cut after save", {28'h0, outs()}, 32'hC);
    if (early) begin
      @(negedge clk);
      chk("R7 pending wake acted on", {28'h0, outs()}, 32'hA);
    end else begin
      repeat (4) @(negedge clk);
      chk("R8 stays cut", pwr_off_req, 1'b1);
      wake_in = 4'b0100;
      repeat (3) @(negedge clk);
      wake_in = 4'b0000;
      chk("R6 hold with freeze", {28'h0, outs()}, 32'hA);
    end
    n = 0;
    while (chip_rst_hold && !xfer_req && n < 100) begin n++; @(negedge clk); end
    chk("R6 hold before restore", n, HOLD_N);
    chk("R6 restore requested", {27'h0, outs(), xfer_dir}, 32'h17);
    repeat (3) @(negedge clk);
    chk("R6 waits for done", {27'h0, outs(), xfer_dir}, 32'h17);
    pulse_done();
    chk("R6 all released", {28'h0, outs()}, 32'h0);
    rd(2'd1, v);
    chk(early ? "R7 status" : "R9 standby status", v, early ? 16'h0101 : 16'h0104);
    wr(2'd1, 16'h010F);
    rd(2'd1, v); chk("R9 all cleared", v, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_irq();
    t_none();
    t_clk_susp();
    t_power_down();
    t_standby(1'b0);
    t_standby(1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule